// File: doc/BRIEF.md
# Interrupt Pending/Active Tracker

This block keeps the service state of a small bank of interrupt request lines (eight by default). Each line may be driven either as a held level or as a single-cycle pulse. No per-line mode setting is needed, because one mechanism covers both kinds of request. For every channel the block holds three bits: enabled, pending and active. It presents the lowest-numbered channel that is ready for service to the core as a request flag plus an index.

The core acknowledges a channel when it starts the handler and signals a return when the handler finishes. On that return the block samples the line level again, so a level request that is still held is not lost. A rising edge that arrives while the handler is running pends the channel again, so a pulse request is not lost either.

Software reaches the bits through a small write port. The port can set or clear pending bits, set or clear enable bits with write-one masks, and pend a single channel given by its number. All three state vectors are visible at the outputs.

Top module: `irq_tracker`

## Requirements
- R1: After reset, the pending, enable and active vectors are all zero and `req_o` is 0.
- R2: For a channel that is not active, a request line that is high in a cycle makes that channel pending in the next cycle. This holds for a held level and for a one-cycle pulse.
- R3: When `ack_valid` is high with `ack_id` = k, in the next cycle channel k is active and its pending bit is clear. The only exceptions are a rising edge on line k or a software set in that same cycle.
- R4: While a channel is active, a rising edge on its line sets pending again. A line held high with no new edge leaves pending clear. The edge is detected against the line's value in the previous cycle.
- R5: When `ret_valid` is high with `ret_id` = k, channel k is no longer active in the next cycle. If line k is high in that return cycle, channel k is pending in the next cycle.
- R6: The enable bit is independent of the pending bit. A disabled channel still becomes and stays pending, but it is offered on `req_o` only while it is enabled.
- R7: A write with `wr_sel` = 0 sets every pending bit whose `wr_data` bit is 1. A write with `wr_sel` = 1 clears every pending bit whose `wr_data` bit is 1. Bits written as 0 keep their value.
- R8: A write with `wr_sel` = 2 sets enable bits, and a write with `wr_sel` = 3 clears enable bits. Only the bits written as 1 change.
- R9: A write with `wr_sel` = 4 pends the single channel whose number is in `wr_data[IW-1:0]`, where IW = $clog2(N).
- R10: When a hardware request and a software clear-pending target the same channel in the same cycle, the channel ends up pending.
- R11: `req_o` is 1 exactly when some channel is pending, enabled and not active. `req_id` is then the lowest such channel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | N | Raw request lines, synchronous to clk |
| ack_valid | input | 1 | Core acknowledges a channel (handler entry) |
| ack_id | input | $clog2(N) | Channel being acknowledged |
| ret_valid | input | 1 | Core returns from a channel's handler |
| ret_id | input | $clog2(N) | Channel being returned from |
| wr_en | input | 1 | Register port write strobe |
| wr_sel | input | 3 | 0 set-pend, 1 clear-pend, 2 set-enable, 3 clear-enable, 4 trigger |
| wr_data | input | N | Bit mask, or channel number in low bits for trigger |
| pend_o | output | N | Pending bits |
| en_o | output | N | Enable bits |
| act_o | output | N | Active bits |
| req_o | output | 1 | A channel is ready for service |
| req_id | output | $clog2(N) | Lowest ready channel |

## Verification
The assertions assume two things about the core. First, it never acknowledges and returns from the same channel in one cycle. Second, it acknowledges only the channel currently offered on `req_id`. The stimulus respects both assumptions. It acknowledges only the index that its own model predicts is offered. It returns only from a channel that the model holds as active, and it drops a return that would collide with an acknowledge of the same channel. Line activity, write operations and handler timing are otherwise random, mixed with directed cases for pulses, held levels across a return, and set-versus-clear collisions.

// File: rtl/irq_tracker.sv
module irq_tracker #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         irq_line,
  input  logic                 ack_valid,
  input  logic [$clog2(N)-1:0] ack_id,
  input  logic                 ret_valid,
  input  logic [$clog2(N)-1:0] ret_id,
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  logic [N-1:0]         wr_data,
  output logic [N-1:0]         pend_o,
  output logic [N-1:0]         en_o,
  output logic [N-1:0]         act_o,
  output logic                 req_o,
  output logic [$clog2(N)-1:0] req_id
);
  localparam int IW = $clog2(N);
  localparam logic [2:0] OP_SETP = 3'd0;
  localparam logic [2:0] OP_CLRP = 3'd1;
  localparam logic [2:0] OP_SETE = 3'd2;
  localparam logic [2:0] OP_CLRE = 3'd3;
  localparam logic [2:0] OP_TRIG = 3'd4;
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] pend_q, en_q, act_q, line_q;
  logic [N-1:0] ack_m, ret_m, trig_m, rise, eff_act, hw_set;
  logic [N-1:0] set_p, clr_p, set_e, clr_e, ready;

  assign ack_m  = ack_valid ? (ONE << ack_id) : '0;
  assign ret_m  = ret_valid ? (ONE << ret_id) : '0;
  assign set_p  = (wr_en && wr_sel == OP_SETP) ? wr_data : '0;
  assign clr_p  = (wr_en && wr_sel == OP_CLRP) ? wr_data : '0;
  assign set_e  = (wr_en && wr_sel == OP_SETE) ? wr_data : '0;
  assign clr_e  = (wr_en && wr_sel == OP_CLRE) ? wr_data : '0;
  assign trig_m = (wr_en && wr_sel == OP_TRIG) ? (ONE << wr_data[IW-1:0]) : '0;

  assign rise    = irq_line & ~line_q;
  assign eff_act = (act_q & ~ret_m) | ack_m;
  assign hw_set  = (eff_act & rise) | (~eff_act & irq_line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      act_q  <= '0;
      line_q <= '0;
    end else begin
      pend_q <= hw_set | set_p | trig_m | (pend_q & ~clr_p & ~ack_m);
      en_q   <= (en_q | set_e) & ~clr_e;
      act_q  <= eff_act;
      line_q <= irq_line;
    end
  end

  assign ready = pend_q & en_q & ~act_q;

  always_comb begin
    req_o  = 1'b0;
    req_id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ready[i]) begin
        req_o  = 1'b1;
        req_id = IW'(i);
      end
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign act_o  = act_q;
endmodule

module irq_tracker_chk #(
  parameter int N = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         irq_line,
  input logic                 ack_valid,
  input logic [$clog2(N)-1:0] ack_id,
  input logic                 ret_valid,
  input logic [$clog2(N)-1:0] ret_id,
  input logic                 wr_en,
  input logic [2:0]           wr_sel,
  input logic [N-1:0]         wr_data,
  input logic [N-1:0]         pend_o,
  input logic [N-1:0]         en_o,
  input logic [N-1:0]         act_o,
  input logic                 req_o,
  input logic [$clog2(N)-1:0] req_id
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};
  logic [N-1:0] ack_m, lvl_m, below;
  assign ack_m = ack_valid ? (ONE << ack_id) : '0;
  assign lvl_m = irq_line & ~act_o & ~ack_m;
  assign below = (ONE << req_id) - ONE;

  // R3
  ack_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> act_o[$past(ack_id)]);
  // R3
  ack_ret_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ret_valid) |-> (ack_id != ret_id));
  // R5
  ret_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !(ack_valid && ack_id == ret_id)) |=> !act_o[$past(ret_id)]);
  // R2
  level_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & $past(lvl_m)) == $past(lvl_m)));
  // R8
  set_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd2) |=> ((en_o & $past(wr_data)) == $past(wr_data)));
  // R11
  offer_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (pend_o[req_id] && en_o[req_id] && !act_o[req_id]));
  // R11
  offer_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> ((pend_o & en_o & ~act_o & below) == '0));
  // R11
  ack_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (req_o && ack_id == req_id));
endmodule

bind irq_tracker irq_tracker_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
  .ack_valid(ack_valid), .ack_id(ack_id), .ret_valid(ret_valid), .ret_id(ret_id),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .pend_o(pend_o), .en_o(en_o), .act_o(act_o), .req_o(req_o), .req_id(req_id)
);

// File: tb/sim_irq_tracker.sv
`timescale 1ns/1ps
module sim_irq_tracker;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_line = '0;
  logic ack_valid = 1'b0;
  logic [IW-1:0] ack_id = '0;
  logic ret_valid = 1'b0;
  logic [IW-1:0] ret_id = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] pend_o, en_o, act_o;
  logic req_o;
  logic [IW-1:0] req_id;

  int checks = 0;
  int fails = 0;
  logic [N-1:0] m_p = '0, m_e = '0, m_a = '0, m_lq = '0;

  always #4 clk = ~clk;

  irq_tracker #(.N(N)) u0 (.*);

  function automatic logic [N-1:0] bit_of(input logic [IW-1:0] k);
    return {{(N-1){1'b0}}, 1'b1} << k;
  endfunction

  function automatic logic m_req();
    return |(m_p & m_e & ~m_a);
  endfunction

  function automatic logic [IW-1:0] m_req_id();
    logic [N-1:0] r = m_p & m_e & ~m_a;
    for (int i = 0; i < N; i++) if (r[i]) return IW'(i);
    return '0;
  endfunction

  task automatic model_step();
    logic [N-1:0] am, rm, act_n, hw, sp, cp, trg;
    am = ack_valid ? bit_of(ack_id) : '0;
    rm = ret_valid ? bit_of(ret_id) : '0;
    act_n = (m_a & ~rm) | am;
    hw = '0;
    for (int i = 0; i < N; i++)
      hw[i] = act_n[i] ? (irq_line[i] && !m_lq[i]) : irq_line[i];
    sp  = (wr_en && wr_sel == 3'd0) ? wr_data : '0;
    cp  = (wr_en && wr_sel == 3'd1) ? wr_data : '0;
    trg = (wr_en && wr_sel == 3'd4) ? bit_of(wr_data[IW-1:0]) : '0;
    m_p = hw | sp | trg | (m_p & ~cp & ~am);
    if (wr_en && wr_sel == 3'd2) m_e = m_e | wr_data;
    if (wr_en && wr_sel == 3'd3) m_e = m_e & ~wr_data;
    m_a = act_n;
    m_lq = irq_line;
  endtask

  task automatic check(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "pending", pend_o, m_p);
    check(tag, "enable", en_o, m_e);
    check(tag, "active", act_o, m_a);
    check("R11", "req_o", N'(req_o), N'(m_req()));
    if (m_req()) check("R11", "req_id", N'(req_id), N'(m_req_id()));
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all(tag);
    ack_valid = 1'b0; ret_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [N-1:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
  endtask

  task automatic do_ack();
    ack_valid = 1'b1; ack_id = m_req_id();
  endtask

  task automatic do_ret(input logic [IW-1:0] k);
    ret_valid = 1'b1; ret_id = k;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    cyc("R1");

    wr(3'd2, 8'hDF); cyc("R8");
    irq_line = 8'h04; cyc("R2");
    irq_line = 8'h00; cyc("R2");
    do_ack(); cyc("R3");
    irq_line = 8'h04; cyc("R4");
    cyc("R4");
    irq_line = 8'h00; do_ret(3'd2); cyc("R5");
    do_ack(); cyc("R3");
    irq_line = 8'h04; cyc("R4");
    do_ret(3'd2); cyc("R5");
    irq_line = 8'h00; do_ack(); cyc("R3");
    do_ret(3'd2); cyc("R5");
    irq_line = 8'h20; cyc("R6");
    irq_line = 8'h00; cyc("R6");
    wr(3'd2, 8'h20); cyc("R6");
    do_ack(); cyc("R6");
    do_ret(3'd5); cyc("R5");
    wr(3'd0, 8'h81); cyc("R7");
    wr(3'd1, 8'h01); cyc("R7");
    wr(3'd1, 8'h00); cyc("R7");
    wr(3'd3, 8'h80); cyc("R8");
    wr(3'd4, 8'h03); cyc("R9");
    wr(3'd4, 8'h06); cyc("R9");
    irq_line = 8'h08; wr(3'd1, 8'hFF); cyc("R10");
    irq_line = 8'h00; wr(3'd1, 8'hFF); cyc("R7");
    wr(3'd2, 8'hFF); cyc("R8");

    for (int n = 0; n < 4000; n++) begin
      logic [IW-1:0] j;
      irq_line = ($urandom_range(0, 3) == 0) ? N'($urandom) : (irq_line & N'($urandom));
      if (m_req() && $urandom_range(0, 2) == 0) do_ack();
      j = IW'($urandom_range(0, N - 1));
      if (m_a[j] && $urandom_range(0, 2) == 0 && !(ack_valid && ack_id == j)) do_ret(j);
      if ($urandom_range(0, 4) == 0) wr(3'($urandom_range(0, 4)), N'($urandom));
      cyc("R11");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule